// File: doc/BRIEF.md
# Packed-Lane Carry-Less Multiplier

This is a purely combinational unit that carries out several independent carry-less (polynomial over GF(2)) multiplies in parallel inside one 64-bit word. Partial products are combined with XOR instead of addition. A 3-bit mode input selects how the two 64-bit operands are split into elements and where each product is placed in the 64-bit result.

The block is meant for the vector datapath of a processor or a checksum/hash engine. It handles several lane formats:
- eight byte products cut down to 8 bits;
- four byte-by-byte products widened to 16 bits, taking either the even bytes, the odd bytes, or four bytes packed in the low half of the word;
- two halfword products widened to 32 bits, from the even or the odd halfwords;
- a single 32-by-32 product widened to 64 bits.

No product ever carries into a neighbouring lane. The result depends only on the present inputs, with no cycle of latency.

Top module: `plm_packed_clmul`

## Requirements
- R1: With mode 0 (byte-truncated), result bits [8k+7:8k] equal the low 8 bits of the carry-less product of operand bytes k of `op_a` and `op_b`, for k = 0..7.
- R2: With mode 0, a byte lane whose operand byte in either input is zero yields a zero result byte, whatever the other lanes hold; nothing crosses a byte boundary.
- R3: With mode 1 (even bytes), result bits [16k+15:16k] equal the 16-bit carry-less product of bytes 2k of the operands. The odd bytes of both operands have no effect.
- R4: With mode 2 (odd bytes), result bits [16k+15:16k] equal the 16-bit carry-less product of bytes 2k+1 of the operands. The even bytes have no effect.
- R5: With mode 3 (packed bytes), result bits [16k+15:16k] equal the 16-bit carry-less product of bytes k (k = 0..3) taken from bits [31:0] of each operand. Bits [63:32] have no effect.
- R6: With mode 4 (even halfwords), result bits [32k+31:32k] equal the 32-bit carry-less product of halfwords 2k of the operands. The odd halfwords have no effect.
- R7: With mode 5 (odd halfwords), result bits [32k+31:32k] equal the 32-bit carry-less product of halfwords 2k+1 of the operands.
- R8: With mode 6 (word), the result equals the 64-bit carry-less product of bits [31:0] of both operands. Bits [63:32] have no effect.
- R9: Mode 7 is unused and drives a zero result.
- R10: In the widening modes the top bit of every product field is always zero: bit 16k+15 in modes 1 to 3, bit 32k+31 in modes 4 and 5, and bit 63 in mode 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First operand word |
| op_b | input | 64 | Second operand word |
| mode | input | 3 | Lane format select, encoded as in R1 to R9 |
| result | output | 64 | Packed products |

## Verification
The hardest case to reach from the ports is the one where a product would bleed into its neighbour. That happens only when the operand bits at the top of each element are set, since those produce the highest-degree terms. Uniform random data sets them only half the time per lane, and rarely in every lane at once. The stimulus therefore mixes random words with directed all-ones words and single-lane patterns, which load the top element bits. Separate runs flip only the ignored bytes, halfwords or upper word and confirm that the result does not change.

// File: rtl/plm_pkg.sv
package plm_pkg;
    localparam int WORD_W = 64;

    typedef enum logic [2:0] {
        MODE_BYTE_TRUNC = 3'd0,
        MODE_BYTE_EVEN  = 3'd1,
        MODE_BYTE_ODD   = 3'd2,
        MODE_BYTE_PACK  = 3'd3,
        MODE_HALF_EVEN  = 3'd4,
        MODE_HALF_ODD   = 3'd5,
        MODE_WORD       = 3'd6,
        MODE_UNUSED     = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        GRP_B8, GRP_B16, GRP_H32, GRP_W64, GRP_NONE
    } grp_e;

    typedef struct packed {
        logic [WORD_W-1:0] x;
        logic [WORD_W-1:0] y;
        grp_e              grp;
    } prep_t;

    // spread four bytes of a 32-bit value into the low byte of each halfword
    function automatic logic [WORD_W-1:0] spread_bytes(input logic [WORD_W/2-1:0] v);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int k = 0; k < WORD_W/16; k++) r[16*k +: 8] = v[8*k +: 8];
        return r;
    endfunction
endpackage

// File: rtl/plm_operand_prep.sv
module plm_operand_prep
    import plm_pkg::*;
(
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [2:0]        mode,
    output prep_t             prep
);
    always_comb begin
        prep.x   = op_a;
        prep.y   = op_b;
        prep.grp = GRP_NONE;
        case (mode_e'(mode))
            MODE_BYTE_TRUNC: prep.grp = GRP_B8;
            MODE_BYTE_EVEN:  prep.grp = GRP_B16;
            MODE_BYTE_ODD: begin
                prep.x   = op_a >> 8;
                prep.y   = op_b >> 8;
                prep.grp = GRP_B16;
            end
            MODE_BYTE_PACK: begin
                prep.x   = spread_bytes(op_a[WORD_W/2-1:0]);
                prep.y   = spread_bytes(op_b[WORD_W/2-1:0]);
                prep.grp = GRP_B16;
            end
            MODE_HALF_EVEN:  prep.grp = GRP_H32;
            MODE_HALF_ODD: begin
                prep.x   = op_a >> 16;
                prep.y   = op_b >> 16;
                prep.grp = GRP_H32;
            end
            MODE_WORD:       prep.grp = GRP_W64;
            default:         prep.grp = GRP_NONE;
        endcase
    end
endmodule

// File: rtl/plm_lane_mul.sv
module plm_lane_mul #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  x,
    input  logic [IN_W-1:0]  y,
    output logic [OUT_W-1:0] p
);
    logic [OUT_W-1:0] y_ext;
    assign y_ext = OUT_W'(y);

    always_comb begin
        p = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (x[i]) p = p ^ (y_ext << i);
        end
    end
endmodule

// File: rtl/plm_lane_bank.sv
module plm_lane_bank #(
    parameter int W     = 64,
    parameter int LANES = 4,
    parameter int IN_W  = 8,
    parameter int OUT_W = 16
) (
    input  logic [LANES*IN_W-1:0] x,
    input  logic [LANES*IN_W-1:0] y,
    output logic [W-1:0]          p
);
    localparam int LANE_W = W / LANES;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [OUT_W-1:0] prod;
        plm_lane_mul #(.IN_W(IN_W), .OUT_W(OUT_W)) u_mul (
            .x (x[k*IN_W +: IN_W]),
            .y (y[k*IN_W +: IN_W]),
            .p (prod)
        );
        assign p[k*LANE_W +: LANE_W] = LANE_W'(prod);
    end
endmodule

// File: rtl/plm_packed_clmul.sv
module plm_packed_clmul
    import plm_pkg::*;
(
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    input  logic [2:0]  mode,
    output logic [63:0] result
);
    localparam int N16 = WORD_W / 16;
    localparam int N32 = WORD_W / 32;

    prep_t prep;
    logic [WORD_W-1:0]    p8, p16, p32, p64;
    logic [N16*8-1:0]     x16, y16;
    logic [N32*16-1:0]    x32, y32;

    plm_operand_prep u_prep (.op_a(op_a), .op_b(op_b), .mode(mode), .prep(prep));

    // compact the low element of each lane slot for the widening banks
    for (genvar k = 0; k < N16; k++) begin : g_c16
        assign x16[8*k +: 8] = prep.x[16*k +: 8];
        assign y16[8*k +: 8] = prep.y[16*k +: 8];
    end
    for (genvar k = 0; k < N32; k++) begin : g_c32
        assign x32[16*k +: 16] = prep.x[32*k +: 16];
        assign y32[16*k +: 16] = prep.y[32*k +: 16];
    end

    plm_lane_bank #(.W(WORD_W), .LANES(WORD_W/8), .IN_W(8), .OUT_W(8)) u_b8 (
        .x(prep.x), .y(prep.y), .p(p8));
    plm_lane_bank #(.W(WORD_W), .LANES(N16), .IN_W(8), .OUT_W(16)) u_b16 (
        .x(x16), .y(y16), .p(p16));
    plm_lane_bank #(.W(WORD_W), .LANES(N32), .IN_W(16), .OUT_W(32)) u_h32 (
        .x(x32), .y(y32), .p(p32));
    plm_lane_bank #(.W(WORD_W), .LANES(1), .IN_W(WORD_W/2), .OUT_W(WORD_W)) u_w64 (
        .x(prep.x[WORD_W/2-1:0]), .y(prep.y[WORD_W/2-1:0]), .p(p64));

    always_comb begin
        case (prep.grp)
            GRP_B8:  result = p8;
            GRP_B16: result = p16;
            GRP_H32: result = p32;
            GRP_W64: result = p64;
            default: result = '0;
        endcase
    end

    always_comb begin
        // R9: unused code gives zero
        a_r9_unused_zero: assert (mode != 3'd7 || result == '0);
        // R10: top bit of each widened product field stays clear
        if (mode inside {3'd1, 3'd2, 3'd3}) begin
            for (int k = 0; k < N16; k++)
                a_r10_b16_top: assert (result[16*k+15] == 1'b0);
        end
        if (mode inside {3'd4, 3'd5}) begin
            for (int k = 0; k < N32; k++)
                a_r10_h32_top: assert (result[32*k+31] == 1'b0);
        end
        a_r10_w64_top: assert (mode != 3'd6 || result[63] == 1'b0);
        // R2: zero operand byte isolates its own lane
        if (mode == 3'd0) begin
            for (int k = 0; k < 8; k++)
                a_r2_lane_iso: assert (!(op_a[8*k +: 8] == 8'd0 || op_b[8*k +: 8] == 8'd0)
                                       || result[8*k +: 8] == 8'd0);
        end
        // R3 / R4: zero source byte gives a zero halfword
        if (mode == 3'd1) begin
            for (int k = 0; k < 4; k++)
                a_r3_even_zero: assert (op_a[16*k +: 8] != 8'd0 || result[16*k +: 16] == 16'd0);
        end
        if (mode == 3'd2) begin
            for (int k = 0; k < 4; k++)
                a_r4_odd_zero: assert (op_b[16*k+8 +: 8] != 8'd0 || result[16*k +: 16] == 16'd0);
        end
        // R5: packed mode sees only the low word
        a_r5_pack_zero: assert (mode != 3'd3 || op_a[31:0] != 32'd0 || result == '0);
    end
endmodule

// File: tb/sim_plm_packed_clmul.sv
module sim_plm_packed_clmul;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] op_a, op_b, result;
    logic [2:0]  mode;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    plm_packed_clmul u0 (.op_a(op_a), .op_b(op_b), .mode(mode), .result(result));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] clm(input logic [31:0] x, input logic [31:0] y);
        logic [63:0] r = '0;
        for (int i = 0; i < 32; i++) if (x[i]) r ^= {32'd0, y} << i;
        return r;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [2:0] m);
        logic [63:0] r = '0;
        logic [63:0] t;
        case (m)
            3'd0: for (int k = 0; k < 8; k++) begin
                      t = clm({24'd0, a[8*k +: 8]}, {24'd0, b[8*k +: 8]});
                      r[8*k +: 8] = t[7:0];
                  end
            3'd1: for (int k = 0; k < 4; k++) begin
                      t = clm({24'd0, a[16*k +: 8]}, {24'd0, b[16*k +: 8]});
                      r[16*k +: 16] = t[15:0];
                  end
            3'd2: for (int k = 0; k < 4; k++) begin
                      t = clm({24'd0, a[16*k+8 +: 8]}, {24'd0, b[16*k+8 +: 8]});
                      r[16*k +: 16] = t[15:0];
                  end
            3'd3: for (int k = 0; k < 4; k++) begin
                      t = clm({24'd0, a[8*k +: 8]}, {24'd0, b[8*k +: 8]});
                      r[16*k +: 16] = t[15:0];
                  end
            3'd4: for (int k = 0; k < 2; k++) begin
                      t = clm({16'd0, a[32*k +: 16]}, {16'd0, b[32*k +: 16]});
                      r[32*k +: 32] = t[31:0];
                  end
            3'd5: for (int k = 0; k < 2; k++) begin
                      t = clm({16'd0, a[32*k+16 +: 16]}, {16'd0, b[32*k+16 +: 16]});
                      r[32*k +: 32] = t[31:0];
                  end
            3'd6: r = clm(a[31:0], b[31:0]);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string rtag(input logic [2:0] m);
        case (m)
            3'd0: return "R1"; 3'd1: return "R3"; 3'd2: return "R4"; 3'd3: return "R5";
            3'd4: return "R6"; 3'd5: return "R7"; 3'd6: return "R8"; default: return "R9";
        endcase
    endfunction

    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [2:0] m);
        @(negedge clk);
        op_a = a; op_b = b; mode = m;
        #1;
    endtask

    task automatic check(input string req, input logic [63:0] exp);
        n_checks++;
        if (result !== exp) begin
            n_errors++;
            $display("FAIL %s mode=%0d a=%h b=%h got=%h exp=%h", req, mode, op_a, op_b, result, exp);
        end
    endtask

    task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [2:0] m);
        apply(a, b, m);
        check(rtag(m), model(a, b, m));
    endtask

    // apply x/y, then x^flip / y^flip; outputs must match
    task automatic ignored(input string req, input logic [63:0] a, input logic [63:0] b,
                           input logic [2:0] m, input logic [63:0] flip);
        logic [63:0] first;
        apply(a, b, m);
        first = model(a, b, m);
        check(req, first);
        apply(a ^ flip, b ^ flip, m);
        check(req, first);
    endtask

    initial begin
        int unsigned seed = 32'd1234;
        logic [63:0] ra, rb;
        op_a = '0; op_b = '0; mode = 3'd7;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        check("R9 idle", 64'd0);

        // directed corner cases
        run({8{8'hFF}}, {8{8'hFF}}, 3'd0);
        apply({8{8'hFF}}, {8{8'hFF}}, 3'd0);
        check("R1 all-ones", {8{8'h55}});
        apply(64'h0000_00FF_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0);
        check("R2 single lane", 64'h0000_0055_0000_0000);
        apply({8{8'hFF}}, {8{8'hFF}}, 3'd1);
        check("R3 all-ones", {4{16'h5555}});
        apply({8{8'hFF}}, {8{8'hFF}}, 3'd6);
        check("R8 all-ones", 64'h5555_5555_5555_5555);
        apply({8{8'hFF}}, {8{8'hFF}}, 3'd4);
        check("R6 all-ones", {2{32'h5555_5555}});
        apply(64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 3'd5);
        check("R7 top bits", {2{32'h4000_0000}});
        apply({8{8'hFF}}, {8{8'hFF}}, 3'd7);
        check("R9 unused", 64'd0);
        apply(64'h0000_0000_0000_0080, 64'h0000_0000_0000_0080, 3'd0);
        check("R2 no carry out", 64'd0);

        // ignored-field checks
        ignored("R3 odd bytes ignored", 64'h1234_5678_9ABC_DEF0, 64'h0F1E_2D3C_4B5A_6978, 3'd1, 64'hFF00_FF00_FF00_FF00);
        ignored("R4 even bytes ignored", 64'h1234_5678_9ABC_DEF0, 64'h0F1E_2D3C_4B5A_6978, 3'd2, 64'h00FF_00FF_00FF_00FF);
        ignored("R5 upper word ignored", 64'h1234_5678_9ABC_DEF0, 64'h0F1E_2D3C_4B5A_6978, 3'd3, 64'hFFFF_FFFF_0000_0000);
        ignored("R6 odd halves ignored", 64'h1234_5678_9ABC_DEF0, 64'h0F1E_2D3C_4B5A_6978, 3'd4, 64'hFFFF_0000_FFFF_0000);
        ignored("R8 upper word ignored", 64'h1234_5678_9ABC_DEF0, 64'h0F1E_2D3C_4B5A_6978, 3'd6, 64'hFFFF_FFFF_0000_0000);

        // constrained random: every mode, plus a share of dense-top-bit words
        for (int n = 0; n < 400; n++) begin
            ra = {$urandom(seed), $urandom};
            rb = {$urandom, $urandom};
            if (n % 4 == 0) begin
                ra = ra | 64'h8080_8080_8080_8080;
                rb = rb | 64'h8080_8080_8080_8080;
            end
            run(ra, rb, 3'(n % 8));
            if (mode inside {3'd1, 3'd2, 3'd3}) begin
                n_checks++;
                for (int k = 0; k < 4; k++)
                    if (result[16*k+15] !== 1'b0) begin
                        n_errors++;
                        $display("FAIL R10 lane %0d got=%b exp=0", k, result[16*k+15]);
                    end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule